// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block sits beside the page-load controller of a byte-programmable nonvolatile array. It watches every byte write for two fixed command sequences. It decides whether each byte the controller loads may go into the array. One short three-byte prefix arms a persistent protect state, and the same prefix opens a single protected load period for real data. A longer six-byte sequence clears the protect state. A change of protect state takes effect only when the page controller reports that the current load period has ended. This holds even when no data bytes follow the command.

Each write event gives its result one clock later. The result is a single-cycle pulse on `write_allowed` (store the byte), on `suppress_data` (a command byte, never stored) or on `start_dummy_timer`. The last pulse means the protected write was refused, but the controller must still run a full write-cycle timer so that polling behaves as for a real write. Only the low 15 address bits take part in command matching.

Top module: `wprot_cmd_seq`

## Requirements
- R1: The arming prefix is 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Every byte of this prefix produces `suppress_data`=1 with `write_allowed`=0 and `start_dummy_timer`=0, one cycle after its event.
- R2: After a complete arming prefix, `protect_state` becomes 1 on the clock edge that samples `load_end`. This happens even if no data byte followed the prefix.
- R3: The disarm sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six bytes are suppressed, and `protect_state` becomes 0 at the next `load_end`.
- R4: `protect_state` changes only on an edge that samples `load_end`. Between load ends it holds its value, including the value after a finished command.
- R5: While protected, ordinary bytes that follow a complete prefix in the same load period give `write_allowed`=1. After the next `load_end`, the unlock is gone.
- R6: While protected and not unlocked, an ordinary byte gives `write_allowed`=0. The first such byte in a load period also gives `start_dummy_timer`=1, and later ones in that period give 0.
- R7: While unprotected, any byte that is not a command byte gives `write_allowed`=1 and `start_dummy_timer`=0.
- R8: A byte that breaks a sequence midway returns the recognizer to idle. That byte is handled as an ordinary write, so a command address can be written with normal data.
- R9: Address bits above bit 14 are ignored for command matching.
- R10: After reset, `protect_state` is 0 and all three pulse outputs are 0.
- R11: A `load_end` discards a partly received sequence, so a final prefix byte that arrives after it is an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle byte write event |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| load_end | input | 1 | One-cycle pulse: load/write period finished |
| protect_state | output | 1 | Persistent write-protect state |
| write_allowed | output | 1 | Pulse: store this byte |
| suppress_data | output | 1 | Pulse: command byte, do not store |
| start_dummy_timer | output | 1 | Pulse: refused write, run the write timer anyway |

## Verification
The assertions assume that `wr_valid` and `load_end` are never high in the same cycle, and that each is a single-cycle pulse. They also assume that no write event arrives in the reset cycle. Because of these assumptions, "protect changes only at a load end" and "the unlock is gone after a load end" can be stated without guarding against a write in the same cycle. The stimulus drives every event and every load-end pulse from tasks that raise the signal for one cycle. There is at least one idle cycle between them, so the two signals never overlap.

// File: rtl/wpseq_pkg.sv
`timescale 1ns/1ps
package wpseq_pkg;
   localparam int CMP_W = 15;
   localparam logic [CMP_W-1:0] ADR_HI = 15'h5555;
   localparam logic [CMP_W-1:0] ADR_LO = 15'h2AAA;
   localparam logic [7:0] B_LEAD  = 8'hAA;
   localparam logic [7:0] B_SECND = 8'h55;
   localparam logic [7:0] B_ARM   = 8'hA0;
   localparam logic [7:0] B_XTND  = 8'h80;
   localparam logic [7:0] B_DSRM  = 8'h20;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_P1, SQ_P2, SQ_D3, SQ_D4, SQ_D5
   } seq_state_t;

   typedef struct packed {
      logic lead_hi;
      logic secnd_lo;
      logic arm_hi;
      logic xtnd_hi;
      logic dsrm_hi;
   } hit_t;
endpackage

// File: rtl/wpseq_match.sv
`timescale 1ns/1ps
module wpseq_match
   import wpseq_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output hit_t              hit
);
   logic [CMP_W-1:0] low_addr;
   logic             at_hi, at_lo;

   generate
      if (ADDR_W < CMP_W) begin : g_bad
         $error("wpseq_match: ADDR_W must be at least 15");
      end
      if (ADDR_W > CMP_W) begin : g_wide
         logic addr_top_unused;
         assign addr_top_unused = ^addr[ADDR_W-1:CMP_W];
      end
   endgenerate

   assign low_addr = addr[CMP_W-1:0];
   assign at_hi    = (low_addr == ADR_HI);
   assign at_lo    = (low_addr == ADR_LO);

   always_comb begin
      hit.lead_hi  = at_hi && (data == B_LEAD);
      hit.secnd_lo = at_lo && (data == B_SECND);
      hit.arm_hi   = at_hi && (data == B_ARM);
      hit.xtnd_hi  = at_hi && (data == B_XTND);
      hit.dsrm_hi  = at_hi && (data == B_DSRM);
   end
endmodule

// File: rtl/wpseq_fsm.sv
`timescale 1ns/1ps
module wpseq_fsm
   import wpseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic clr,
   input  hit_t hit,
   output logic cmd_byte,
   output logic arm,
   output logic disarm,
   output logic plain
);
   seq_state_t state, nxt;

   always_comb begin
      nxt      = state;
      cmd_byte = 1'b0;
      arm      = 1'b0;
      disarm   = 1'b0;
      plain    = 1'b0;
      if (ev) begin
         nxt   = SQ_IDLE;
         plain = 1'b1;
         unique case (state)
            SQ_IDLE: if (hit.lead_hi)  begin nxt = SQ_P1; plain = 1'b0; cmd_byte = 1'b1; end
            SQ_P1:   if (hit.secnd_lo) begin nxt = SQ_P2; plain = 1'b0; cmd_byte = 1'b1; end
            SQ_P2: begin
               if (hit.arm_hi) begin
                  plain = 1'b0; cmd_byte = 1'b1; arm = 1'b1;
               end else if (hit.xtnd_hi) begin
                  nxt = SQ_D3; plain = 1'b0; cmd_byte = 1'b1;
               end
            end
            SQ_D3:   if (hit.lead_hi)  begin nxt = SQ_D4; plain = 1'b0; cmd_byte = 1'b1; end
            SQ_D4:   if (hit.secnd_lo) begin nxt = SQ_D5; plain = 1'b0; cmd_byte = 1'b1; end
            SQ_D5:   if (hit.dsrm_hi)  begin plain = 1'b0; cmd_byte = 1'b1; disarm = 1'b1; end
            default: ;
         endcase
      end
      if (clr) nxt = SQ_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= nxt;
   end

   // R11: a load end drops any partial sequence
   p_clear_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == SQ_IDLE));
   // R8: a non-command byte always leaves the recognizer idle
   p_break_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && plain) |=> (state == SQ_IDLE));
endmodule

// File: rtl/wpseq_gate.sv
`timescale 1ns/1ps
module wpseq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_byte,
   input  logic arm,
   input  logic disarm,
   input  logic plain,
   input  logic period_end,
   output logic protect_q,
   output logic allow_c,
   output logic supp_c,
   output logic dummy_c
);
   logic unlock_q, pend_on, pend_off, dummy_q, blocked;

   assign blocked = plain && protect_q && !unlock_q;
   assign allow_c = plain && !blocked;
   assign supp_c  = cmd_byte;
   assign dummy_c = blocked && !dummy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         protect_q <= 1'b0;
         unlock_q  <= 1'b0;
         pend_on   <= 1'b0;
         pend_off  <= 1'b0;
         dummy_q   <= 1'b0;
      end else if (period_end) begin
         if (pend_on)       protect_q <= 1'b1;
         else if (pend_off) protect_q <= 1'b0;
         unlock_q <= 1'b0;
         pend_on  <= 1'b0;
         pend_off <= 1'b0;
         dummy_q  <= 1'b0;
      end else begin
         if (arm)    begin pend_on  <= 1'b1; pend_off <= 1'b0; unlock_q <= 1'b1; end
         if (disarm) begin pend_off <= 1'b1; pend_on  <= 1'b0; unlock_q <= 1'b1; end
         if (blocked) dummy_q <= 1'b1;
      end
   end

   // R4: protect state moves only at a load end
   p_protect_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(protect_q));
   // R5: the unlock never outlives its load period
   p_unlock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> !unlock_q);
   // R2: a finished arming prefix sets protection at the period end
   p_arm_applies_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !period_end) |=> (period_end |=> protect_q));
endmodule

// File: rtl/wprot_cmd_seq.sv
`timescale 1ns/1ps
module wprot_cmd_seq
   import wpseq_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              load_end,
   output logic              protect_state,
   output logic              write_allowed,
   output logic              suppress_data,
   output logic              start_dummy_timer
);
   hit_t hit;
   logic cmd_byte, arm, disarm, plain;
   logic allow_c, supp_c, dummy_c;

   wpseq_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(wr_addr), .data(wr_data), .hit(hit)
   );

   wpseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ev(wr_valid), .clr(load_end), .hit(hit),
      .cmd_byte(cmd_byte), .arm(arm), .disarm(disarm), .plain(plain)
   );

   wpseq_gate u_gate (
      .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .arm(arm),
      .disarm(disarm), .plain(plain), .period_end(load_end),
      .protect_q(protect_state), .allow_c(allow_c), .supp_c(supp_c),
      .dummy_c(dummy_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               write_allowed     <= 1'b0;
               suppress_data     <= 1'b0;
               start_dummy_timer <= 1'b0;
            end else begin
               write_allowed     <= allow_c;
               suppress_data     <= supp_c;
               start_dummy_timer <= dummy_c;
            end
         end
         // R10: no pulse without a preceding write event
         p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_valid |=> !(write_allowed || suppress_data || start_dummy_timer));
      end else begin : g_comb
         assign write_allowed     = allow_c;
         assign suppress_data     = supp_c;
         assign start_dummy_timer = dummy_c;
      end
   endgenerate

   // R1: a command byte is never stored nor charged a timer
   p_cmd_not_stored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      suppress_data |-> !(write_allowed || start_dummy_timer));
   // R6: a dummy timer start only accompanies a refused byte
   p_dummy_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_dummy_timer |-> !write_allowed);
endmodule

// File: tb/wprot_cmd_seq_test.sv
`timescale 1ns/1ps
module wprot_cmd_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        load_end = 1'b0;
   logic        protect_state, write_allowed, suppress_data, start_dummy_timer;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   wprot_cmd_seq #(.ADDR_W(19)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .load_end(load_end), .protect_state(protect_state),
      .write_allowed(write_allowed), .suppress_data(suppress_data),
      .start_dummy_timer(start_dummy_timer)
   );

   // Monitor: the event sampled at this edge has its result visible just after it
   always @(posedge clk) begin
      #1;
      if (wr_valid) begin
         logic [2:0] got, exp;
         string tg;
         got = {write_allowed, suppress_data, start_dummy_timer};
         exp = exp_q.pop_front();
         tg  = tag_q.pop_front();
         checks++;
         if (got !== exp) begin
            fails++;
            $display("FAIL %s: {allow,suppress,dummy} actual %b expected %b", tg, got, exp);
         end
      end
   end

   task automatic wr(input logic [18:0] a, input logic [7:0] d,
                     input bit al, input bit sp, input bit dm, input string tg);
      @(negedge clk);
      exp_q.push_back({al, sp, dm});
      tag_q.push_back(tg);
      wr_addr  = a;
      wr_data  = d;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic period_end();
      @(negedge clk);
      load_end = 1'b1;
      @(negedge clk);
      load_end = 1'b0;
   endtask

   task automatic chk_prot(input bit exp, input string tg);
      @(negedge clk);
      checks++;
      if (protect_state !== exp) begin
         fails++;
         $display("FAIL %s: protect_state actual %b expected %b", tg, protect_state, exp);
      end
   endtask

   task automatic prefix(input string tg);
      wr(19'h05555, 8'hAA, 0, 1, 0, tg);
      wr(19'h02AAA, 8'h55, 0, 1, 0, tg);
      wr(19'h05555, 8'hA0, 0, 1, 0, tg);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if ({protect_state, write_allowed, suppress_data, start_dummy_timer} !== 4'b0000) begin
         fails++;
         $display("FAIL R10: outputs in reset actual %b expected 0000",
                  {protect_state, write_allowed, suppress_data, start_dummy_timer});
      end
      rst_n = 1'b1;
      chk_prot(0, "R10");

      wr(19'h00100, 8'h11, 1, 0, 0, "R7");
      wr(19'h00101, 8'h12, 1, 0, 0, "R7");
      period_end();

      prefix("R1");
      chk_prot(0, "R4");
      period_end();
      chk_prot(1, "R2");

      wr(19'h00200, 8'h01, 0, 0, 1, "R6");
      wr(19'h00201, 8'h02, 0, 0, 0, "R6");
      period_end();
      chk_prot(1, "R4");

      prefix("R5");
      wr(19'h00300, 8'h33, 1, 0, 0, "R5");
      wr(19'h00301, 8'h34, 1, 0, 0, "R5");
      period_end();
      wr(19'h00302, 8'h35, 0, 0, 1, "R5");
      period_end();

      wr(19'h05555, 8'hAA, 0, 1, 0, "R8");
      wr(19'h02AAA, 8'h56, 0, 0, 1, "R8");
      wr(19'h05555, 8'hA0, 0, 0, 0, "R8");
      period_end();

      wr(19'h75555, 8'hAA, 0, 1, 0, "R9");
      wr(19'h42AAA, 8'h55, 0, 1, 0, "R9");
      wr(19'h15555, 8'hA0, 0, 1, 0, "R9");
      wr(19'h00400, 8'h44, 1, 0, 0, "R9");
      period_end();

      wr(19'h05555, 8'hAA, 0, 1, 0, "R11");
      wr(19'h02AAA, 8'h55, 0, 1, 0, "R11");
      period_end();
      wr(19'h05555, 8'hA0, 0, 0, 1, "R11");
      period_end();

      wr(19'h05555, 8'hAA, 0, 1, 0, "R3");
      wr(19'h02AAA, 8'h55, 0, 1, 0, "R3");
      wr(19'h05555, 8'h80, 0, 1, 0, "R3");
      wr(19'h05555, 8'hAA, 0, 1, 0, "R3");
      wr(19'h02AAA, 8'h55, 0, 1, 0, "R3");
      wr(19'h05555, 8'h20, 0, 1, 0, "R3");
      chk_prot(1, "R4");
      wr(19'h00500, 8'h55, 1, 0, 0, "R3");
      period_end();
      chk_prot(0, "R3");
      wr(19'h00501, 8'h56, 1, 0, 0, "R7");

      wr(19'h05555, 8'hAA, 0, 1, 0, "R8");
      wr(19'h05555, 8'h12, 1, 0, 0, "R8");
      period_end();
      chk_prot(0, "R4");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R10: watchdog expired, actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule